// File: doc/BRIEF.md
# Burst Line-Fill Bus Interface

This unit sits between a cache controller and a memory bus of the cycle/strobe/acknowledge kind. The cache asks for either a four-word line fill or a single-word fetch. The unit then runs the bus handshake and returns each word with a valid strobe. The transfer ends with a one-clock done pulse, or with an error pulse if the bus reports a fault.

The unit is tuned for a fast on-chip SRAM. Strobe and cycle stay asserted across consecutive beats, so a zero-wait memory can acknowledge on every clock. A line fill then finishes four clocks after the first beat. For slower slaves, a compatible mode drops the strobe for one clock between beats, so each beat costs two clocks. The mode is taken from `fill_slow_i` when a request is accepted.

All bus outputs are registered. A beat whose acknowledge is low is held without limit. A retry response makes the unit reissue the same beat, and an error response ends the transfer at once.

Top module: `linefill_biu`

## Requirements
- R1: For a line fill, the four beats use the addresses B, B+4, B+8 and B+12 in that order. B is the request address with its low 4 bits cleared, and the sequence does not wrap.
- R2: In fast mode, the strobe stays high in the clock after a non-final acknowledge. With a zero-wait slave, the four acknowledges fall in clocks 1 to 4 and done comes in clock 5. Clock 1 is the first clock with cycle high.
- R3: In slow mode, the strobe is low and cycle is high for exactly one clock after each non-final acknowledge. With a zero-wait slave, done comes in clock 8.
- R4: A single fetch makes one beat at the request address with its low 2 bits cleared. With a zero-wait slave, done comes in clock 2.
- R5: Each acknowledged word appears on `word_data_o`, with `word_valid_o` high, in the clock after its acknowledge. No valid is given in any other clock.
- R6: Done is high for exactly one clock, in the clock after the final acknowledge. In that clock cycle and strobe are both low.
- R7: While a strobed beat receives no acknowledge, error or retry, the strobe stays high and the address stays stable in the next clock. There is no limit on the number of such wait clocks.
- R8: A retry without acknowledge or error drops the strobe for one clock while cycle stays high. The unit then reissues the same address, and no data is returned for the retried beat.
- R9: An error on a strobed beat takes priority over acknowledge. In the next clock cycle and strobe are low and `fill_err_o` pulses for one clock. No done follows, and no valid is given for that beat.
- R10: A request is taken only while the unit is idle. A request during a transfer does not change its addresses or its length.
- R11: After reset, cycle, strobe, valid, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req_i | input | 1 | Transfer request; sampled only while idle |
| fill_single_i | input | 1 | 1 = single-word fetch, 0 = four-word line fill |
| fill_slow_i | input | 1 | 1 = two-clock beats, 0 = back-to-back beats |
| fill_addr_i | input | AW | Request byte address |
| word_valid_o | output | 1 | A returned word is on `word_data_o` |
| word_data_o | output | DW | Returned word |
| fill_done_o | output | 1 | One-clock pulse: transfer completed |
| fill_err_o | output | 1 | One-clock pulse: transfer aborted by a bus error |
| bus_cyc_o | output | 1 | Bus cycle in progress |
| bus_stb_o | output | 1 | Beat strobe |
| bus_adr_o | output | AW | Beat byte address |
| bus_dat_i | input | DW | Read data from the slave |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_err_i | input | 1 | Beat error |
| bus_rty_i | input | 1 | Beat retry |

## Verification
The hardest situations to reach are a retry or an error on the last beats of a burst. This matters most in fast mode, where the next strobe has already been committed in the same clock. The bench's memory stub is programmed per transfer. It can be set to a wait count, the beat index that answers with retry (once), and the beat index that answers with error. The sweep then places a retry and an error on each of the four beat positions, in both modes and for several wait counts. For each case the bench checks the exact completion clock, which it computes from the wait count, the mode and the retry penalty.

// File: rtl/lf_pkg.sv
// Shared types for the burst line-fill bus interface.
package lf_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // no transfer; cycle low
        SEQ_BEAT = 2'd1,   // strobe presented to the bus
        SEQ_GAP  = 2'd2    // cycle held, strobe dropped for one clock
    } seq_st_t;
endpackage

// File: rtl/lf_addr_gen.sv
// Beat address generator.
// Loads the aligned start address of a transfer and steps it by one bus
// word per accepted beat. It also flags the final beat of the transfer.
// Assumes BEATS is a power of two (at least 2) and DW is a multiple of 8.
module lf_addr_gen #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          single_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    output logic [AW-1:0] adr_o,
    output logic          last_o
);
    localparam int BYTES = DW / 8;
    localparam int WOFF  = $clog2(BYTES);
    localparam int OFFW  = $clog2(BEATS * BYTES);
    localparam int BW    = $clog2(BEATS);

    logic [AW-1:0] adr_q;
    logic [BW-1:0] beat_q;
    logic          single_q;

    // Load the aligned start address, or advance by one word per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q    <= '0;
            beat_q   <= '0;
            single_q <= 1'b0;
        end else if (load_i) begin
            adr_q    <= single_i ? {base_i[AW-1:WOFF], {WOFF{1'b0}}}
                                 : {base_i[AW-1:OFFW], {OFFW{1'b0}}};
            beat_q   <= '0;
            single_q <= single_i;
        end else if (step_i) begin
            adr_q    <= adr_q + AW'(BYTES);
            beat_q   <= beat_q + 1'b1;
        end
    end

    // The final beat is beat 0 of a single fetch, or the last beat of a line.
    always_comb last_o = single_q || (beat_q == BW'(BEATS - 1));

    assign adr_o = adr_q;

    AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> adr_o == $past(adr_o) + AW'(BYTES)); // R1
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !single_i) |=> adr_o[OFFW-1:0] == '0); // R1
endmodule

// File: rtl/lf_seq.sv
// Bus cycle/strobe sequencer.
// Opens a bus cycle on a request taken while idle and presents one strobe
// per beat. It holds through wait states, inserts a one-clock gap after a
// retry or (in slow mode) after each beat, and closes the cycle on the
// final acknowledge or on an error. Error wins over acknowledge, and
// acknowledge wins over retry. Done and fail are one-clock registered pulses.
module lf_seq
    import lf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic slow_i,
    input  logic ack_i,
    input  logic err_i,
    input  logic rty_i,
    input  logic last_i,
    output logic cyc_o,
    output logic stb_o,
    output logic load_o,
    output logic take_o,
    output logic step_o,
    output logic done_o,
    output logic fail_o
);
    seq_st_t st_q;
    logic    slow_q;

    // Request acceptance and beat qualification from registered state.
    always_comb begin
        load_o = (st_q == SEQ_IDLE) && req_i;
        take_o = (st_q == SEQ_BEAT) && ack_i && !err_i;
        step_o = take_o && !last_i;
    end

    // Transfer state machine with registered completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            slow_q <= 1'b0;
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
            unique case (st_q)
                SEQ_IDLE: if (req_i) begin
                    st_q   <= SEQ_BEAT;
                    slow_q <= slow_i;
                end
                SEQ_BEAT: begin
                    if (err_i) begin
                        st_q   <= SEQ_IDLE;
                        fail_o <= 1'b1;
                    end else if (ack_i) begin
                        if (last_i) begin
                            st_q   <= SEQ_IDLE;
                            done_o <= 1'b1;
                        end else if (slow_q) begin
                            st_q <= SEQ_GAP;
                        end
                    end else if (rty_i) begin
                        st_q <= SEQ_GAP;
                    end
                end
                SEQ_GAP:  st_q <= SEQ_BEAT;
                default:  st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign cyc_o = (st_q != SEQ_IDLE);
    assign stb_o = (st_q == SEQ_BEAT);

    AST_FAST_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && !err_i && !last_i && !slow_q) |=> stb_o); // R2
    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && !err_i && !last_i && slow_q) |=> (!stb_o && cyc_o)); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && !err_i && last_i) |=> (done_o && !cyc_o)); // R6
    AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && rty_i && !ack_i && !err_i) |=> (!stb_o && cyc_o && !done_o)); // R8
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && err_i) |=> (fail_o && !cyc_o && !done_o)); // R9
endmodule

// File: rtl/linefill_biu.sv
// Burst line-fill bus interface (top).
// Connects a cache controller to a cycle/strobe/acknowledge memory bus.
// It runs four-word line fills or single-word fetches, in fast
// (back-to-back) or slow (two clocks per beat) mode. Returned words are
// registered toward the cache one clock after their acknowledge.
// Assumes the cache holds the request for one clock and waits for done or
// error before asking again.
module linefill_biu #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_req_i,
    input  logic          fill_single_i,
    input  logic          fill_slow_i,
    input  logic [AW-1:0] fill_addr_i,
    output logic          word_valid_o,
    output logic [DW-1:0] word_data_o,
    output logic          fill_done_o,
    output logic          fill_err_o,
    output logic          bus_cyc_o,
    output logic          bus_stb_o,
    output logic [AW-1:0] bus_adr_o,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack_i,
    input  logic          bus_err_i,
    input  logic          bus_rty_i
);
    logic load, take, step, last;

    lf_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (fill_req_i),
        .slow_i (fill_slow_i),
        .ack_i  (bus_ack_i),
        .err_i  (bus_err_i),
        .rty_i  (bus_rty_i),
        .last_i (last),
        .cyc_o  (bus_cyc_o),
        .stb_o  (bus_stb_o),
        .load_o (load),
        .take_o (take),
        .step_o (step),
        .done_o (fill_done_o),
        .fail_o (fill_err_o)
    );

    lf_addr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_adr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .single_i (fill_single_i),
        .base_i   (fill_addr_i),
        .step_i   (step),
        .adr_o    (bus_adr_o),
        .last_o   (last)
    );

    // Register each accepted word toward the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid_o <= 1'b0;
            word_data_o  <= '0;
        end else begin
            word_valid_o <= take;
            if (take) word_data_o <= bus_dat_i;
        end
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb_o && !bus_ack_i && !bus_err_i && !bus_rty_i)
        |=> (bus_stb_o && $stable(bus_adr_o))); // R7
    AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb_o |-> bus_cyc_o); // R8
    AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb_o && bus_ack_i && !bus_err_i) |=> word_valid_o); // R5
    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_done_o && fill_err_o)); // R9
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && fill_req_i && !bus_ack_i && !bus_rty_i && !bus_err_i)
        |=> $stable(bus_adr_o)); // R10
endmodule

// File: tb/tb_linefill_biu.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps mode, size, wait count, base address and
// retry/error beat position against a programmable zero-wait-capable stub.
module tb_linefill_biu;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_req = 1'b0, fill_single = 1'b0, fill_slow = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          word_valid, fill_done, fill_err, bus_cyc, bus_stb;
    logic [DW-1:0] word_data, bus_dat;
    logic [AW-1:0] bus_adr;
    logic          bus_ack, bus_err, bus_rty;

    int n_run = 0, n_fail = 0, cyc_cnt = 0;

    // stub configuration (set by the tasks while the bus is idle)
    int w_cfg = 0, rty_cfg = -1, err_cfg = -1;
    int wcnt = 0, stub_beat = 0;
    logic rty_used = 1'b0;

    always #2 clk = ~clk;

    linefill_biu #(.AW(AW), .DW(DW), .BEATS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .fill_req_i(fill_req), .fill_single_i(fill_single),
        .fill_slow_i(fill_slow), .fill_addr_i(fill_addr),
        .word_valid_o(word_valid), .word_data_o(word_data),
        .fill_done_o(fill_done), .fill_err_o(fill_err),
        .bus_cyc_o(bus_cyc), .bus_stb_o(bus_stb), .bus_adr_o(bus_adr),
        .bus_dat_i(bus_dat), .bus_ack_i(bus_ack),
        .bus_err_i(bus_err), .bus_rty_i(bus_rty)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // memory stub: answers once the strobe has waited w_cfg clocks
    logic slot;
    assign slot    = bus_cyc && bus_stb && (wcnt == w_cfg);
    assign bus_err = slot && (stub_beat == err_cfg);
    assign bus_rty = slot && !bus_err && !rty_used && (stub_beat == rty_cfg);
    assign bus_ack = slot && !bus_err && !bus_rty;
    assign bus_dat = memf(bus_adr);

    always_ff @(posedge clk) begin
        if (!bus_cyc) begin
            wcnt <= 0; stub_beat <= 0; rty_used <= 1'b0;
        end else begin
            wcnt <= (!bus_stb || bus_ack || bus_rty) ? 0 : wcnt + 1;
            if (bus_ack) stub_beat <= stub_beat + 1;
            if (bus_rty) rty_used <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one transfer; all timing counted from clock 1 = first clock with cycle high
    task automatic run(input logic [AW-1:0] base, input bit single, input bit slow,
                       input int w, input int rb, input int eb);
        int n = single ? 1 : 4;
        int exp_done = n * (w + 1) + (slow ? n - 1 : 0) + ((rb >= 0 && rb < n) ? w + 2 : 0) + 1;
        int exp_err  = eb * (w + 1) + (slow ? eb : 0) + w + 2;
        logic [AW-1:0] eb_adr = single ? {base[AW-1:2], 2'b00} : {base[AW-1:4], 4'b0000};
        int beat = 0;
        bit prev_ack = 0, prev_last = 0, prev_wait = 0, prev_rty = 0, pend_rty = 0, fin = 0;
        logic [AW-1:0] prev_adr = '0, rty_adr = '0;
        w_cfg = w; rty_cfg = rb; err_cfg = eb;
        @(negedge clk);
        fill_req = 1'b1; fill_addr = base; fill_single = single; fill_slow = slow;
        @(negedge clk);
        fill_req = 1'b0;
        for (int k = 1; k < 100 && !fin; k++) begin
            check(word_valid == prev_ack, "R5 valid timing", word_valid, prev_ack);
            if (word_valid) check(word_data == memf(prev_adr), "R5 data", word_data, memf(prev_adr));
            if (prev_ack && !prev_last) begin
                if (slow) check(!bus_stb && bus_cyc, "R3 gap", {bus_cyc, bus_stb}, 2'b10);
                else      check(bus_stb, "R2 back-to-back", bus_stb, 1);
            end
            if (prev_wait) check(bus_stb && bus_adr == prev_adr, "R7 hold", bus_adr, prev_adr);
            if (prev_rty) begin
                check(!bus_stb && bus_cyc, "R8 retry gap", {bus_cyc, bus_stb}, 2'b10);
                pend_rty = 1;
            end else if (pend_rty && bus_stb) begin
                check(bus_adr == rty_adr, "R8 reissue", bus_adr, rty_adr);
                pend_rty = 0;
            end
            if (bus_ack) begin
                check(bus_adr == eb_adr + AW'(4 * beat), k > 2 ? "R10 addr" : (single ? "R4 addr" : "R1 addr"),
                      bus_adr, eb_adr + AW'(4 * beat));
                beat++;
            end
            if (fill_done) begin
                check(eb < 0 && k == exp_done, single ? "R4 done clock" : (slow ? "R3 done clock" : "R2 done clock"),
                      k, exp_done);
                check(!bus_cyc && !bus_stb && beat == n, "R6 done state", beat, n);
                fin = 1;
            end
            if (fill_err) begin
                check(eb >= 0 && k == exp_err && !bus_cyc && !bus_stb, "R9 error clock", k, exp_err);
                fin = 1;
            end
            if (bus_rty) rty_adr = bus_adr;
            prev_ack  = bus_ack;
            prev_last = bus_ack && (beat == n);
            prev_wait = bus_stb && !bus_ack && !bus_rty && !bus_err;
            prev_rty  = bus_rty && !bus_ack && !bus_err;
            prev_adr  = bus_adr;
            // R10: a foreign request during the transfer must be ignored
            if (k == 2 && !fin && bus_cyc) begin
                fill_req = 1'b1; fill_addr = ~base;
            end else begin
                fill_req = 1'b0;
            end
            @(negedge clk);
        end
        fill_req = 1'b0;
        check(fin, "R6 transfer ended", fin, 1);
        check(!fill_done && !fill_err && !bus_cyc && !word_valid, "R6 single pulse",
              {fill_done, fill_err, bus_cyc, word_valid}, 0);
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] bases [3] = '{32'h0000_1000, 32'h0000_203C, 32'hFFFF_FFF7};
        repeat (3) @(negedge clk);
        check(!bus_cyc && !bus_stb && !word_valid && !fill_done && !fill_err, "R11 reset",
              {bus_cyc, bus_stb, word_valid, fill_done, fill_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++)
            for (int sl = 0; sl < 2; sl++)
                for (int w = 0; w < 3; w++)
                    for (int b = 0; b < 3; b++)
                        run(bases[b], s[0], sl[0], w, -1, -1);
        for (int sl = 0; sl < 2; sl++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 4; p++) begin
                    run(32'h0000_4010, 1'b0, sl[0], w, p, -1);  // R8 sweep
                    run(32'h0000_4010, 1'b0, sl[0], w, -1, p);  // R9 sweep
                end
        run(32'h0000_5004, 1'b1, 1'b0, 0, 0, -1);
        run(32'h0000_5004, 1'b1, 1'b1, 1, -1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule